// File: doc/BRIEF.md
# SRAM Bank Power and Erase Sequencer

This block brings a set of equal-size SRAM banks up and down as a group. A power-down command walks the banks and, for each one, first marks it disabled and then closes its power switch. A power-up command walks the banks too, but it only touches a bank that is still gated or still disabled. For such a bank it opens the power switch, waits a fixed warm-up interval, re-enables the bank, and then starts an external erase engine over the whole bank. It waits for that engine to go idle before it moves on.

After every bank it visits, the sequencer pulses a clear strobe for the SRAM interrupt status. When the last bank is finished it raises a one-cycle done pulse. The erase engine sits outside the block and reports activity on a busy input. A parameter can keep the highest bank powered through a power-down, for example when that bank holds state that must survive.

Top module: `sram_bank_pwr_seq`

## Requirements
- R1: After reset every bank is gated (`gate_o` all ones), every disable bit in `cfg_o` is set, `cfg_o[3:0]` is zero, and `busy_o` and `done_o` are low.
- R2: On power-down, each bank's disable bit (`cfg_o[i+4]`) is set one cycle before its gate bit (`gate_o[i]`), and banks are handled in ascending index order.
- R3: With `KEEP_LAST`=1 (the default), a power-down leaves the highest bank ungated and enabled, and it does not visit that bank.
- R4: On power-up of a bank, `gate_o[i]` clears first and `cfg_o[i+4]` clears exactly `WARM_CYC` clock edges later.
- R5: After a bank is enabled, `erase_start_o` pulses for one cycle. While it is high, `erase_addr_o` equals `SRAM_BASE + i*BANK_BYTES` and `erase_ctrl_o` carries the zero-based dword count `BANK_BYTES/4-1` in bits [31:2], 0 in bit 1 and 1 in bit 0. For 32 KiB banks this is 0x0000_7FFD.
- R6: The sequencer does not leave a bank while `erase_busy_i` is high.
- R7: On power-up, a bank that is neither gated nor disabled is not erased and its controls do not change.
- R8: `irq_clr_o` pulses once for each bank visited. That is all banks on power-up, and the non-excluded banks on power-down.
- R9: `done_o` is high for exactly one cycle after the last bank, and `busy_o` is high from the cycle after the command until the done cycle.
- R10: A command that arrives while `busy_o` is high is ignored.
- R11: If power-up and power-down commands arrive in the same idle cycle, power-up wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_on_i | input | 1 | Power-up request, one-cycle pulse |
| cmd_off_i | input | 1 | Power-down request, one-cycle pulse |
| erase_busy_i | input | 1 | Erase engine busy |
| gate_o | output | NBANK | Power gate per bank, 1 = gated |
| cfg_o | output | NBANK+4 | Bank configuration word; bit i+4 = 1 disables bank i, bits [3:0] are 0 |
| erase_addr_o | output | AW | Erase start address |
| erase_ctrl_o | output | 32 | Erase control word: zero-based dword count in [31:2], start in bit 0 |
| erase_start_o | output | 1 | Erase start pulse |
| irq_clr_o | output | 1 | Write-all-ones strobe for SRAM interrupt status |
| done_o | output | 1 | Sequence complete pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions check the per-bank ordering on every cycle. A gate may only rise on a bank that is already disabled, and a disable bit may only fall on a bank that was already ungated in the previous cycle. They also check that the start and done strobes are single-cycle, that the erase start never overlaps a busy engine, and that the outputs hold still while idle. The bench scenarios are needed for everything that depends on what a whole command did: the exact warm-up distance, the erase addresses and their order, skipping of banks that are already powered, the kept last bank, the count of interrupt clears, and the handling of ignored and simultaneous commands.

// File: rtl/sbps_pkg.sv
package sbps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_GATE,
        ST_WARM,
        ST_ERASE_GO,
        ST_ERASE_WAIT,
        ST_CLR,
        ST_DONE
    } sbps_state_e;
endpackage

// File: rtl/sbps_warm_timer.sv
module sbps_warm_timer #(
    parameter int unsigned WARM_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(WARM_CYC + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = CW'(WARM_CYC - 1);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired_o = tmr_q.run && (tmr_q.cnt == '0);

    // The timer is never reloaded while a warm-up is still counting.
    assert_no_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !tmr_q.run);
endmodule

// File: rtl/sbps_erase_fmt.sv
module sbps_erase_fmt #(
    parameter int unsigned         IW         = 2,
    parameter int unsigned         AW         = 32,
    parameter int unsigned         BANK_BYTES = 32768,
    parameter logic [AW-1:0]       SRAM_BASE  = '0
) (
    input  logic [IW-1:0] idx_i,
    input  logic          start_i,
    output logic [AW-1:0] addr_o,
    output logic [31:0]   ctrl_o
);
    localparam logic [29:0] LEN_DW = 30'(BANK_BYTES / 4 - 1);

    assign addr_o = SRAM_BASE + (AW'(idx_i) * AW'(BANK_BYTES));
    assign ctrl_o = {LEN_DW, 1'b0, start_i};
endmodule

// File: rtl/sram_bank_pwr_seq.sv
module sram_bank_pwr_seq
    import sbps_pkg::*;
#(
    parameter int unsigned   NBANK      = 4,
    parameter int unsigned   BANK_BYTES = 32768,
    parameter int unsigned   AW         = 32,
    parameter logic [AW-1:0] SRAM_BASE  = 32'hFF00_0000,
    parameter int unsigned   WARM_CYC   = 10,
    parameter bit            KEEP_LAST  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_on_i,
    input  logic              cmd_off_i,
    input  logic              erase_busy_i,
    output logic [NBANK-1:0]  gate_o,
    output logic [NBANK+3:0]  cfg_o,
    output logic [AW-1:0]     erase_addr_o,
    output logic [31:0]       erase_ctrl_o,
    output logic              erase_start_o,
    output logic              irq_clr_o,
    output logic              done_o,
    output logic              busy_o
);
    localparam int unsigned IW       = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int unsigned OFF_CNT  = KEEP_LAST ? NBANK - 1 : NBANK;
    localparam logic [IW-1:0] LAST_ON_IDX  = IW'(NBANK - 1);
    localparam logic [IW-1:0] LAST_OFF_IDX = IW'((OFF_CNT > 0) ? OFF_CNT - 1 : 0);

    typedef struct packed {
        sbps_state_e      state;
        logic [IW-1:0]    idx;
        logic             mode_on;
        logic [NBANK-1:0] gate;
        logic [NBANK-1:0] dis;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tmr_load, tmr_expired;

    sbps_warm_timer #(.WARM_CYC(WARM_CYC)) u_warm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (cmd_on_i) begin
                    seq_d.mode_on = 1'b1;
                    seq_d.idx     = '0;
                    seq_d.state   = ST_PICK;
                end else if (cmd_off_i) begin
                    seq_d.mode_on = 1'b0;
                    seq_d.idx     = '0;
                    seq_d.state   = (OFF_CNT == 0) ? ST_DONE : ST_PICK;
                end
            end
            ST_PICK: begin
                if (seq_q.mode_on) begin
                    if (seq_q.gate[seq_q.idx] || seq_q.dis[seq_q.idx]) begin
                        seq_d.gate[seq_q.idx] = 1'b0;
                        tmr_load              = 1'b1;
                        seq_d.state           = ST_WARM;
                    end else begin
                        seq_d.state = ST_CLR;
                    end
                end else begin
                    seq_d.dis[seq_q.idx] = 1'b1;
                    seq_d.state          = ST_GATE;
                end
            end
            ST_GATE: begin
                seq_d.gate[seq_q.idx] = 1'b1;
                seq_d.state           = ST_CLR;
            end
            ST_WARM: begin
                if (tmr_expired) begin
                    seq_d.dis[seq_q.idx] = 1'b0;
                    seq_d.state          = ST_ERASE_GO;
                end
            end
            ST_ERASE_GO:   seq_d.state = ST_ERASE_WAIT;
            ST_ERASE_WAIT: if (!erase_busy_i) seq_d.state = ST_CLR;
            ST_CLR: begin
                if (seq_q.idx == (seq_q.mode_on ? LAST_ON_IDX : LAST_OFF_IDX)) begin
                    seq_d.state = ST_DONE;
                end else begin
                    seq_d.idx   = seq_q.idx + 1'b1;
                    seq_d.state = ST_PICK;
                end
            end
            ST_DONE:  seq_d.state = ST_IDLE;
            default:  seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state   <= ST_IDLE;
            seq_q.idx     <= '0;
            seq_q.mode_on <= 1'b0;
            seq_q.gate    <= '1;
            seq_q.dis     <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    sbps_erase_fmt #(
        .IW(IW), .AW(AW), .BANK_BYTES(BANK_BYTES), .SRAM_BASE(SRAM_BASE)
    ) u_fmt (
        .idx_i   (seq_q.idx),
        .start_i (erase_start_o),
        .addr_o  (erase_addr_o),
        .ctrl_o  (erase_ctrl_o)
    );

    assign gate_o        = seq_q.gate;
    assign cfg_o         = {seq_q.dis, 4'b0000};
    assign erase_start_o = (seq_q.state == ST_ERASE_GO);
    assign irq_clr_o     = (seq_q.state == ST_CLR);
    assign done_o        = (seq_q.state == ST_DONE);
    assign busy_o        = (seq_q.state != ST_IDLE);

    // Per-bank ordering between gate and disable controls
    for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
        assert_gate_after_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_o[b]) |-> cfg_o[b+4]);
        assert_enable_after_ungate_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cfg_o[b+4]) |-> (!gate_o[b] && $past(!gate_o[b])));
    end

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_o |=> !erase_start_o);
    assert_start_engine_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_o |-> !erase_busy_i);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> ($stable(gate_o) && $stable(cfg_o)));
endmodule

// File: tb/sram_bank_pwr_seq_tb.sv
module sram_bank_pwr_seq_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          NB    = 4;
    localparam int          BANKB = 32768;
    localparam logic [31:0] BASE  = 32'hFF00_0000;
    localparam int          WARM  = 10;
    localparam logic [31:0] CTRL_EXP = 32'h0000_7FFD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_on = 1'b0, cmd_off = 1'b0;
    logic eng_busy = 1'b0;
    logic [NB-1:0] gate;
    logic [NB+3:0] cfg;
    logic [31:0] eaddr, ectrl;
    logic estart, irqclr, done, busy;

    int checks = 0, fails = 0, cyc = 0;
    int erase_lat = 3, eng_cnt = 0;
    logic [31:0] log_addr [16];
    logic [31:0] log_ctrl [16];
    int n_erase = 0, n_irq = 0, n_done = 0, n_overlap = 0;
    int gfall [NB], dfall [NB], gap [NB], drise [NB], grise [NB];
    logic [NB-1:0] pgate;
    logic [NB-1:0] pdis;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bank_pwr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_on_i(cmd_on), .cmd_off_i(cmd_off),
        .erase_busy_i(eng_busy), .gate_o(gate), .cfg_o(cfg),
        .erase_addr_o(eaddr), .erase_ctrl_o(ectrl), .erase_start_o(estart),
        .irq_clr_o(irqclr), .done_o(done), .busy_o(busy)
    );

    // Erase engine model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (estart) begin
            eng_busy <= 1'b1;
            eng_cnt  <= erase_lat;
        end else if (eng_busy) begin
            if (eng_cnt <= 1) eng_busy <= 1'b0;
            eng_cnt <= eng_cnt - 1;
        end
    end

    // Monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (estart && n_erase < 16) begin
                log_addr[n_erase] = eaddr;
                log_ctrl[n_erase] = ectrl;
            end
            if (estart) n_erase++;
            if (irqclr) n_irq++;
            if (irqclr && eng_busy) n_overlap++;
            if (done) n_done++;
            for (int i = 0; i < NB; i++) begin
                if (pgate[i] && !gate[i]) gfall[i] = cyc;
                if (!pgate[i] && gate[i]) grise[i] = cyc;
                if (pdis[i] && !cfg[i+4]) begin dfall[i] = cyc; gap[i] = cyc - gfall[i]; end
                if (!pdis[i] && cfg[i+4]) drise[i] = cyc;
            end
        end
        pgate = gate;
        pdis  = cfg[NB+3:4];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_erase = 0; n_irq = 0; n_done = 0; n_overlap = 0;
    endtask

    task automatic pulse(input bit on, input bit off);
        @(negedge clk);
        cmd_on = on; cmd_off = off;
        @(negedge clk);
        cmd_on = 1'b0; cmd_off = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin @(negedge clk); guard++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(gate == '1, "R1 gate", 32'(gate), 32'hF);
        chk(cfg == 8'hF0, "R1 cfg", 32'(cfg), 32'hF0);
        chk(!busy && !done, "R1 busy/done", {30'b0, busy, done}, 0);
    endtask

    task automatic t_power_on_all();
        clear_log();
        pulse(1, 0);
        chk(busy, "R9 busy after cmd", 32'(busy), 1);
        wait_idle();
        chk(gate == '0 && cfg == '0, "R4 all on", 32'(cfg) | 32'(gate), 0);
        chk(n_erase == NB, "R5 erase count", n_erase, NB);
        for (int i = 0; i < NB; i++) begin
            chk(log_addr[i] == BASE + 32'(i * BANKB), "R5 addr order", log_addr[i], BASE + 32'(i * BANKB));
            chk(log_ctrl[i] == CTRL_EXP, "R5 ctrl word", log_ctrl[i], CTRL_EXP);
            chk(gap[i] == WARM, "R4 warm gap", gap[i], WARM);
        end
        chk(n_irq == NB, "R8 irq clears on", n_irq, NB);
        chk(n_done == 1, "R9 done pulses", n_done, 1);
        chk(n_overlap == 0, "R6 overlap", n_overlap, 0);
    endtask

    task automatic t_on_again();
        clear_log();
        pulse(1, 0);
        wait_idle();
        chk(n_erase == 0, "R7 no re-erase", n_erase, 0);
        chk(gate == '0 && cfg == '0, "R7 unchanged", 32'(cfg) | 32'(gate), 0);
        chk(n_irq == NB, "R8 irq clears skip", n_irq, NB);
    endtask

    task automatic t_power_off();
        clear_log();
        pulse(0, 1);
        wait_idle();
        chk(gate == 4'b0111, "R3 gate keep last", 32'(gate), 32'h7);
        chk(cfg == 8'h70, "R3 cfg keep last", 32'(cfg), 32'h70);
        for (int i = 0; i < NB - 1; i++) begin
            chk(grise[i] == drise[i] + 1, "R2 disable then gate", grise[i], drise[i] + 1);
            if (i > 0) chk(drise[i] > drise[i-1], "R2 ascending", drise[i], drise[i-1]);
        end
        chk(n_irq == NB - 1, "R8 irq clears off", n_irq, NB - 1);
        chk(n_done == 1, "R9 done off", n_done, 1);
    endtask

    task automatic t_partial_on_slow();
        erase_lat = 40;
        clear_log();
        pulse(1, 0);
        wait_idle();
        chk(n_erase == NB - 1, "R7 partial erase count", n_erase, NB - 1);
        chk(log_addr[2] == BASE + 32'(2 * BANKB), "R5 partial addr", log_addr[2], BASE + 32'(2 * BANKB));
        chk(n_overlap == 0, "R6 waits for engine", n_overlap, 0);
        chk(n_irq == NB, "R8 irq partial", n_irq, NB);
        erase_lat = 3;
    endtask

    task automatic t_ignore_busy();
        pulse(0, 1);
        wait_idle();
        clear_log();
        pulse(1, 0);
        repeat (5) @(negedge clk);
        pulse(0, 1);
        wait_idle();
        chk(gate == '0 && cfg == '0, "R10 off ignored", 32'(cfg) | 32'(gate), 0);
        chk(n_done == 1, "R10 single sequence", n_done, 1);
    endtask

    task automatic t_both();
        clear_log();
        pulse(1, 1);
        wait_idle();
        chk(gate == '0 && cfg == '0, "R11 on wins", 32'(cfg) | 32'(gate), 0);
        chk(n_erase == 0 && n_irq == NB, "R11 on path", n_irq, NB);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_power_on_all();
        t_on_again();
        t_power_off();
        t_partial_on_slow();
        t_ignore_busy();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule